// File: doc/BRIEF.md
# Stop Mode Wake-Up Controller

This block runs the low-power stop state of a small microcontroller's system integration logic. When the CPU requests stop, the block drops the enables of both derived system clocks. This halts the CPU and every peripheral. The block then waits for a wake event. A module interrupt or a break request starts a timed recovery on the oscillator-rate clock. Reset returns the block to normal running at once.

The recovery length is fixed by a configuration bit. With the bit set, recovery takes a short count, suited to a ready-made oscillator. With the bit clear, it takes a long count, suited to a crystal that needs time to start. The bit is captured at the moment the stop request is accepted. The recovery counter stays cleared for the whole stopped period and starts counting only when recovery begins. When recovery ends, the clock enables return and a one-cycle pulse tells the interrupt logic that stacking may begin. A break that arrives during stop sets a sticky status flag. Software clears this flag with a write-one strobe.

Top module: `stop_wake_ctrl`

## Requirements
- R1: An active-low asynchronous reset (`rstN` low) has these effects at once, at any time, including during stop or recovery:
  - it forces the running state;
  - it drives both clock enables high;
  - it holds `stackOk` low;
  - it clears `brkStopFlag`.
  No recovery count follows a reset.
- R2: `stopReq` sampled high while running drives both clock enables low from the next cycle. They stay low until recovery completes. `stopReq` is ignored while stopped or recovering.
- R3: The recovery counter is held at zero from stop acceptance until recovery starts. The time spent stopped therefore has no effect on the recovery length.
- R4: `intReq` or `breakReq` sampled high while stopped starts recovery. Counting from that edge, the clock enables rise exactly LONG_CYCLES (4096) edges later when the captured configuration was 0, and exactly SHORT_CYCLES (32) edges later when it was 1.
- R5: `stackOk` is high for exactly one cycle: the first running cycle after a recovery completes. In that cycle both clock enables are high.
- R6: `breakReq` sampled high while stopped sets `brkStopFlag`. The flag then stays set until `brkClr` or reset clears it. A set wins over a clear in the same cycle. A `breakReq` while running does not set the flag.
- R7: `shortRecCfg` is captured only when a stop request is accepted. Changes to it during stop or recovery do not alter the current recovery length.
- R8: `intReq` and `breakReq` while running have no effect on the clock enables or on `stackOk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock (double rate) |
| rstN | input | 1 | Asynchronous active-low reset, also a wake source |
| stopReq | input | 1 | Stop request from the CPU |
| shortRecCfg | input | 1 | 1 selects short recovery, 0 selects long |
| intReq | input | 1 | Combined module interrupt request |
| breakReq | input | 1 | Break request |
| brkClr | input | 1 | Write-one-to-clear strobe for the break flag |
| cpuClkEn | output | 1 | Enable for the CPU clock |
| busClkEn | output | 1 | Enable for the peripheral clock |
| stackOk | output | 1 | One-cycle pulse: interrupt stacking may begin |
| brkStopFlag | output | 1 | Sticky break-during-stop status |

## Verification
The bench builds the block with its default lengths of 4096 and 32 cycles. This keeps the exact recovery counts for both settings within the run time. It compares each measured wake-to-pulse count against a queued expectation. Waits in stop that exceed the short length show that the counter stays still while stopped. Changing the configuration bit mid-stop shows that the captured value is the one that governs recovery.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_STOPPED, ST_RECOVER} pwrState_e;

  typedef struct packed {
    logic holdCnt;
    logic incCnt;
    logic latchCfg;
    logic setBrk;
  } dpCtrl_t;
endpackage

// File: rtl/stop_fsm.sv
module stop_fsm
  import stop_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stopReq,
  input  logic      intReq,
  input  logic      breakReq,
  input  logic      cntDone,
  output dpCtrl_t   ctl,
  output pwrState_e state,
  output logic      stackOk
);
  pwrState_e stateNext;
  logic wakeEvt;

  assign wakeEvt = intReq | breakReq;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:     if (stopReq) stateNext = ST_STOPPED;
      ST_STOPPED: if (wakeEvt) stateNext = ST_RECOVER;
      ST_RECOVER: if (cntDone) stateNext = ST_RUN;
      default:    stateNext = ST_RUN;
    endcase
  end

  always_comb begin
    ctl.holdCnt  = (state != ST_RECOVER);
    ctl.incCnt   = (state == ST_RECOVER) && !cntDone;
    ctl.latchCfg = (state == ST_RUN) && stopReq;
    ctl.setBrk   = (state == ST_STOPPED) && breakReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      stackOk <= 1'b0;
    end else begin
      state   <= stateNext;
      stackOk <= (state == ST_RECOVER) && cntDone;
    end
  end

  // R2: an accepted stop request leads to the stopped state
  p_stop_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && stopReq) |=> (state == ST_STOPPED));

  // R4: a wake event while stopped begins recovery
  p_wake_exit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOPPED && wakeEvt) |=> (state == ST_RECOVER));

  // R5: the stacking pulse lasts a single cycle and lands in the running state
  p_stack_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    stackOk |=> !stackOk);
  p_stack_in_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    stackOk |-> (state == ST_RUN));
endmodule

// File: rtl/stop_dp.sv
module stop_dp
  import stop_wake_pkg::*;
#(
  parameter int LONG_CYCLES  = 4096,
  parameter int SHORT_CYCLES = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCtrl_t ctl,
  input  logic    shortCfg,
  input  logic    brkClr,
  output logic    cntDone,
  output logic    brkFlag
);
  localparam int CW = (LONG_CYCLES > 1) ? $clog2(LONG_CYCLES) : 1;
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYCLES - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          cfgShort;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgShort <= 1'b0;
    else if (ctl.latchCfg) cfgShort <= shortCfg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (ctl.holdCnt) cnt <= '0;
    else if (ctl.incCnt) cnt <= cnt + 1'b1;
  end

  assign cntDone = cfgShort ? (cnt == SHORT_LAST) : (cnt == LONG_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) brkFlag <= 1'b0;
    else if (ctl.setBrk) brkFlag <= 1'b1;
    else if (brkClr) brkFlag <= 1'b0;
  end

  // R3: the counter stays cleared while it is held
  p_cnt_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.holdCnt |=> (cnt == '0));

  // R7: the captured configuration only changes on stop acceptance
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchCfg |=> $stable(cfgShort));

  // R6: the flag is sticky until cleared
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (brkFlag && !brkClr) |=> brkFlag);
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setBrk |=> brkFlag);
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import stop_wake_pkg::*;
#(
  parameter int LONG_CYCLES  = 4096,
  parameter int SHORT_CYCLES = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic stopReq,
  input  logic shortRecCfg,
  input  logic intReq,
  input  logic breakReq,
  input  logic brkClr,
  output logic cpuClkEn,
  output logic busClkEn,
  output logic stackOk,
  output logic brkStopFlag
);
  dpCtrl_t   ctl;
  pwrState_e state;
  logic      cntDone;

  stop_fsm u_fsm (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .intReq(intReq),
    .breakReq(breakReq), .cntDone(cntDone), .ctl(ctl), .state(state),
    .stackOk(stackOk)
  );

  stop_dp #(.LONG_CYCLES(LONG_CYCLES), .SHORT_CYCLES(SHORT_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .shortCfg(shortRecCfg),
    .brkClr(brkClr), .cntDone(cntDone), .brkFlag(brkStopFlag)
  );

  assign cpuClkEn = (state == ST_RUN);
  assign busClkEn = (state == ST_RUN);

  // R1: after reset release the clocks run
  p_reset_run_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (cpuClkEn && busClkEn && !brkStopFlag));
endmodule

// File: tb/tb_stop_wake_ctrl.sv
module tb_stop_wake_ctrl;
  localparam int LONGC  = 4096;
  localparam int SHORTC = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 1'b0, shortRecCfg = 1'b0, intReq = 1'b0, breakReq = 1'b0, brkClr = 1'b0;
  logic cpuClkEn, busClkEn, stackOk, brkStopFlag;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int wakeCyc = 0;
  int expQ[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stop_wake_ctrl #(.LONG_CYCLES(LONGC), .SHORT_CYCLES(SHORTC)) dut (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .shortRecCfg(shortRecCfg),
    .intReq(intReq), .breakReq(breakReq), .brkClr(brkClr),
    .cpuClkEn(cpuClkEn), .busClkEn(busClkEn), .stackOk(stackOk),
    .brkStopFlag(brkStopFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop the expected recovery length on each stacking pulse
  always @(negedge clk) begin
    if (rstN && stackOk && !done) begin
      if (expQ.size() == 0) chk(1'b0, "R5 unexpected pulse", 1, 0);
      else begin
        int e;
        e = expQ.pop_front();
        chk((cyc - wakeCyc) == e, "R4 recovery length", cyc - wakeCyc, e);
        chk(cpuClkEn && busClkEn, "R5 enables high with pulse", int'(cpuClkEn), 1);
      end
    end
  end

  task automatic enterStop(input bit cfg);
    @(negedge clk);
    stopReq = 1'b1; shortRecCfg = cfg;
    @(negedge clk);
    stopReq = 1'b0;
    chk(!cpuClkEn && !busClkEn, "R2 enables low after stop", int'(cpuClkEn), 0);
  endtask

  task automatic idleStopped(input int n);
    bit bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cpuClkEn || stackOk) bad = 1'b1;
    end
    chk(!bad, "R2 stays stopped", int'(bad), 0);
  endtask

  task automatic wake(input bit useBrk, input int expLen);
    @(negedge clk);
    if (useBrk) breakReq = 1'b1; else intReq = 1'b1;
    wakeCyc = cyc + 1;
    expQ.push_back(expLen);
    @(negedge clk);
    breakReq = 1'b0; intReq = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!cpuClkEn && n < 10000) begin @(negedge clk); n++; end
    chk(stackOk == 1'b1, "R5 pulse at first run cycle", int'(stackOk), 1);
    @(negedge clk);
    chk(stackOk == 1'b0, "R5 pulse one cycle", int'(stackOk), 0);
    chk(expQ.size() == 0, "R4 expected item consumed", expQ.size(), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cpuClkEn && busClkEn && !stackOk && !brkStopFlag, "R1 reset state", int'(cpuClkEn), 1);
    rstN = 1'b1;
    @(negedge clk);

    // R8: wake sources while running do nothing
    intReq = 1'b1; breakReq = 1'b1;
    repeat (3) @(negedge clk);
    chk(cpuClkEn && !stackOk, "R8 wake while running ignored", int'(cpuClkEn), 1);
    chk(!brkStopFlag, "R6 break in run does not set flag", int'(brkStopFlag), 0);
    intReq = 1'b0; breakReq = 1'b0;

    // R4 long recovery via interrupt; R7 cfg change during recovery
    enterStop(1'b0);
    idleStopped(10);
    wake(1'b0, LONGC);
    shortRecCfg = 1'b1;
    waitDone();
    chk(!brkStopFlag, "R6 interrupt wake leaves flag", int'(brkStopFlag), 0);

    // R7 short captured, changed during stop; break wake; R3 long idle
    enterStop(1'b1);
    shortRecCfg = 1'b0;
    idleStopped(300);
    // R2: stop request while stopped ignored
    stopReq = 1'b1;
    wake(1'b1, SHORTC);
    stopReq = 1'b0;
    waitDone();
    chk(brkStopFlag, "R6 break in stop sets flag", int'(brkStopFlag), 1);
    repeat (2) @(negedge clk);
    chk(brkStopFlag, "R6 flag sticky", int'(brkStopFlag), 1);
    brkClr = 1'b1;
    @(negedge clk);
    brkClr = 1'b0;
    chk(!brkStopFlag, "R6 write-one clears flag", int'(brkStopFlag), 0);

    // R3: short stop then short recovery via interrupt
    enterStop(1'b1);
    idleStopped(1);
    wake(1'b0, SHORTC);
    waitDone();

    // R6: set wins over simultaneous clear
    enterStop(1'b1);
    @(negedge clk);
    brkClr = 1'b1;
    wake(1'b1, SHORTC);
    brkClr = 1'b0;
    waitDone();
    chk(brkStopFlag, "R6 set beats clear", int'(brkStopFlag), 1);

    // R1: reset in the middle of recovery
    enterStop(1'b0);
    @(negedge clk);
    intReq = 1'b1;
    @(negedge clk);
    intReq = 1'b0;
    repeat (20) @(negedge clk);
    rstN = 1'b0;
    #1;
    chk(cpuClkEn && busClkEn && !brkStopFlag && !stackOk, "R1 reset mid recovery", int'(cpuClkEn), 1);
    @(negedge clk);
    rstN = 1'b1;
    repeat (40) @(negedge clk);
    chk(cpuClkEn && !stackOk, "R1 no recovery after reset", int'(stackOk), 0);

    // R1: reset as wake from stop
    enterStop(1'b1);
    idleStopped(5);
    rstN = 1'b0;
    #1;
    chk(cpuClkEn, "R1 reset wakes from stop", int'(cpuClkEn), 1);
    @(negedge clk);
    rstN = 1'b1;
    repeat (40) @(negedge clk);
    chk(!stackOk && expQ.size() == 0, "R1 no pulse after reset wake", int'(stackOk), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule